// File: doc/BRIEF.md
# Row-Write Column-Read Matrix Interleaver

This block is a square bit matrix that a host processor uses as a working buffer for block interleaving. The host owns all addressing. In each clock cycle it can store one complete row, fetch one complete column, or do both. An R×C block therefore passes through in R+C cycles.

Before a row is stored, a bank of four-input multiplexers reorders the incoming word. A second bank of the same kind reorders every fetched column. A small table, indexed by the constellation mode and by the row or column address of the current access, selects one of four fixed patterns for each bank.

For deinterleaving, the host swaps the row and column counts and sets the direction bit. The column-side pattern then moves to the row side as its inverse, and the column side passes data straight through. Rows and columns beyond the configured counts are gated off.

Top module: `rcm_interleaver`

## Requirements
- R1: After reset, rd_data is zero and every matrix cell holds zero.
- R2: With wr_en high and wr_row below cfg_rows, the permuted wr_data is stored as that row at the next clock. With rd_en high and rd_col below cfg_cols, bit k of rd_data one cycle later holds row k of that column, before the column permutation is applied.
- R3: A read with rd_col at or above cfg_cols, or a cycle with rd_en low, leaves rd_data unchanged.
- R4: A write with wr_row at or above cfg_rows changes no cell.
- R5: Within a stored row, bit positions at or above cfg_cols keep their previous cell contents.
- R6: Bit positions of rd_data at or above cfg_rows read as zero.
- R7: With cfg_dir=0 (interleave) and cfg_mode 0 or 1 (one or two bits per subcarrier), columns are read out unpermuted and rows are stored unpermuted.
- R8: With cfg_dir=0 and cfg_mode=2 (four bits), even columns pass straight through. Odd columns swap each adjacent bit pair: out[2p]=in[2p+1] and out[2p+1]=in[2p].
- R9: With cfg_dir=0 and cfg_mode=3 (six bits), column c rotates each three-bit group by s=c mod 3: out[3g+k]=in[3g+((k+s) mod 3)].
- R10: With cfg_dir=1 (deinterleave), row r is stored through the inverse of the pattern that R7 to R9 assign to column r, and columns are read unpermuted. Interleaving an R×16 block and then deinterleaving it with the counts swapped gives back the original rows.
- R11: Writes and reads can be issued back to back, one per cycle. An R×C block completes in R+C issue cycles. A read and a write in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rows | input | 5 | Active row count |
| cfg_cols | input | 5 | Active column count |
| cfg_mode | input | 2 | Bits per subcarrier: 0=1, 1=2, 2=4, 3=6 |
| cfg_dir | input | 1 | 0 interleave, 1 deinterleave |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 5 | Row address |
| wr_data | input | 18 | Row word, bit i goes to column i |
| rd_en | input | 1 | Column read strobe |
| rd_col | input | 5 | Column address |
| rd_data | output | 18 | Registered column word, bit k from row k |

## Verification
The hardest situations to reach are those where the outcome depends on the configuration changing between accesses. Two examples are cells kept alive beyond a shrunk column count, and a full interleave followed by a swapped-shape deinterleave that must reproduce the original rows. Directed sequences reach these by narrowing cfg_cols between two writes of the same row and widening it again before the read. They also capture every interleaved column from the ports and feed it back as a deinterleave row. Seeded random traffic then mixes out-of-range addresses, shape changes and simultaneous reads and writes against a bench matrix model.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  typedef enum logic [1:0] {
    MODE_BPSK  = 2'd0,
    MODE_QPSK  = 2'd1,
    MODE_QAM16 = 2'd2,
    MODE_QAM64 = 2'd3
  } rcm_mode_e;

  typedef enum logic [1:0] {
    PSEL_PASS = 2'd0,
    PSEL_PAIR = 2'd1,
    PSEL_ROT1 = 2'd2,
    PSEL_ROT2 = 2'd3
  } rcm_psel_e;

  // Column-side pattern for interleave direction (R7, R8, R9)
  function automatic rcm_psel_e col_psel(input rcm_mode_e m, input int unsigned a);
    rcm_psel_e s;
    s = PSEL_PASS;
    case (m)
      MODE_QAM16: s = (a % 2 == 1) ? PSEL_PAIR : PSEL_PASS;
      MODE_QAM64: begin
        case (a % 3)
          1:       s = PSEL_ROT1;
          2:       s = PSEL_ROT2;
          default: s = PSEL_PASS;
        endcase
      end
      default: s = PSEL_PASS;
    endcase
    return s;
  endfunction

  // Inverse pattern used on the row side when deinterleaving (R10)
  function automatic rcm_psel_e inv_psel(input rcm_psel_e s);
    rcm_psel_e r;
    case (s)
      PSEL_ROT1: r = PSEL_ROT2;
      PSEL_ROT2: r = PSEL_ROT1;
      default:   r = s;
    endcase
    return r;
  endfunction

  // Source bit index feeding output bit i under pattern s
  function automatic int unsigned src_bit(input int unsigned i, input rcm_psel_e s,
                                          input int unsigned w);
    int unsigned j;
    case (s)
      PSEL_PAIR: j = i ^ 1;
      PSEL_ROT1: j = 3 * (i / 3) + ((i % 3) + 1) % 3;
      PSEL_ROT2: j = 3 * (i / 3) + ((i % 3) + 2) % 3;
      default:   j = i;
    endcase
    if (j >= w) j = i;
    return j;
  endfunction

endpackage

// File: rtl/rcm_perm_net.sv
module rcm_perm_net
  import rcm_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] din,
  input  rcm_psel_e    sel,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned SRC_PAIR = src_bit(i, PSEL_PAIR, W);
    localparam int unsigned SRC_ROT1 = src_bit(i, PSEL_ROT1, W);
    localparam int unsigned SRC_ROT2 = src_bit(i, PSEL_ROT2, W);
    logic [3:0] cand;
    assign cand    = {din[SRC_ROT2], din[SRC_ROT1], din[SRC_PAIR], din[i]};
    assign dout[i] = cand[sel];
  end

endmodule

// File: rtl/rcm_ctrl_table.sv
module rcm_ctrl_table
  import rcm_pkg::*;
#(
  parameter int DIM = 18,
  parameter int AW  = 5
) (
  input  rcm_mode_e         mode,
  input  logic              dir,
  input  logic [AW-1:0]     wr_addr,
  input  logic [AW-1:0]     rd_addr,
  output rcm_psel_e         row_sel,
  output rcm_psel_e         col_sel
);

  localparam int NMODE = 4;

  rcm_psel_e lut [NMODE][DIM];
  rcm_psel_e wr_entry;
  rcm_psel_e rd_entry;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    for (genvar a = 0; a < DIM; a++) begin : g_addr
      assign lut[m][a] = col_psel(rcm_mode_e'(m), a);
    end
  end

  always_comb begin
    wr_entry = PSEL_PASS;
    rd_entry = PSEL_PASS;
    if (int'(wr_addr) < DIM) wr_entry = lut[mode][wr_addr];
    if (int'(rd_addr) < DIM) rd_entry = lut[mode][rd_addr];
    row_sel = dir ? inv_psel(wr_entry) : PSEL_PASS;
    col_sel = dir ? PSEL_PASS : rd_entry;
  end

endmodule

// File: rtl/rcm_bit_matrix.sv
module rcm_bit_matrix #(
  parameter int DIM = 18,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DIM-1:0] wr_word,
  input  logic [DIM-1:0] wr_keep,
  input  logic [AW-1:0]  rd_addr,
  output logic [DIM-1:0] col_word
);

  logic [DIM-1:0] cell_q [DIM];
  logic [DIM-1:0] cell_d [DIM];

  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic row_hit;
    assign row_hit = wr_en && (wr_addr == AW'(r));

    always_comb begin
      cell_d[r] = (cell_q[r] & ~wr_keep) | (wr_word & wr_keep);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[r] <= '0;
      end else if (row_hit) begin
        cell_q[r] <= cell_d[r];
      end
    end

    assign col_word[r] = (int'(rd_addr) < DIM) ? cell_q[r][rd_addr] : 1'b0;
  end

endmodule

// File: rtl/rcm_interleaver.sv
module rcm_interleaver
  import rcm_pkg::*;
#(
  parameter  int DIM = 18,
  localparam int AW  = $clog2(DIM),
  localparam int CW  = $clog2(DIM + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cfg_rows,
  input  logic [CW-1:0]  cfg_cols,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_dir,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_row,
  input  logic [DIM-1:0] wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_col,
  output logic [DIM-1:0] rd_data
);

  logic [DIM-1:0] row_keep;
  logic [DIM-1:0] col_keep;
  logic           wr_ok;
  logic           rd_ok;
  rcm_mode_e      mode_e;
  rcm_psel_e      row_sel;
  rcm_psel_e      col_sel;
  logic [DIM-1:0] wr_perm;
  logic [DIM-1:0] col_raw;
  logic [DIM-1:0] col_gated;
  logic [DIM-1:0] col_perm;
  logic [DIM-1:0] rd_d;
  logic [DIM-1:0] rd_q;

  for (genvar i = 0; i < DIM; i++) begin : g_keep
    assign row_keep[i] = (i < int'(cfg_rows));
    assign col_keep[i] = (i < int'(cfg_cols));
  end

  assign mode_e = rcm_mode_e'(cfg_mode);
  assign wr_ok  = wr_en && (int'(wr_row) < int'(cfg_rows)) && (int'(wr_row) < DIM);
  assign rd_ok  = rd_en && (int'(rd_col) < int'(cfg_cols)) && (int'(rd_col) < DIM);

  rcm_ctrl_table #(.DIM(DIM), .AW(AW)) u_tbl (
    .mode    (mode_e),
    .dir     (cfg_dir),
    .wr_addr (wr_row),
    .rd_addr (rd_col),
    .row_sel (row_sel),
    .col_sel (col_sel)
  );

  rcm_perm_net #(.W(DIM)) u_row_perm (
    .din  (wr_data),
    .sel  (row_sel),
    .dout (wr_perm)
  );

  rcm_bit_matrix #(.DIM(DIM), .AW(AW)) u_mat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .wr_addr  (wr_row),
    .wr_word  (wr_perm),
    .wr_keep  (col_keep),
    .rd_addr  (rd_col),
    .col_word (col_raw)
  );

  assign col_gated = col_raw & row_keep;

  rcm_perm_net #(.W(DIM)) u_col_perm (
    .din  (col_gated),
    .sel  (col_sel),
    .dout (col_perm)
  );

  always_comb begin
    rd_d = col_perm & row_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_ok) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/rcm_interleaver_chk.sv
module rcm_interleaver_chk
  import rcm_pkg::*;
#(
  parameter int DIM = 18,
  parameter int AW  = 5,
  parameter int CW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  cfg_rows,
  input logic [CW-1:0]  cfg_cols,
  input logic [1:0]     cfg_mode,
  input logic           cfg_dir,
  input logic           rd_en,
  input logic [AW-1:0]  rd_col,
  input logic [DIM-1:0] rd_data,
  input rcm_psel_e      row_sel,
  input rcm_psel_e      col_sel,
  input logic [DIM-1:0] perm_in,
  input logic [DIM-1:0] perm_out
);

  // R3: idle cycles and out-of-range reads keep the output register
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || (int'(rd_col) >= int'(cfg_cols))) |=> $stable(rd_data));

  // R6: rows beyond the active count never reach the output
  a_r6_high_rows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(rd_col) < int'(cfg_cols))) |=> ((rd_data >> $past(cfg_rows)) == '0));

  // R7: low-order modes leave columns untouched when interleaving
  a_r7_bits_no_colperm: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir && (cfg_mode < 2'd2)) |-> (col_sel == PSEL_PASS));

  // R10: only one side permutes, chosen by direction
  a_r10_one_side_perm: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir ? (col_sel == PSEL_PASS) : (row_sel == PSEL_PASS));

  // R8, R9: the column network only moves bits, never creates or drops them
  a_r9_perm_bijective: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(perm_out) == $countones(perm_in));

endmodule

bind rcm_interleaver rcm_interleaver_chk #(.DIM(DIM), .AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_rows (cfg_rows),
  .cfg_cols (cfg_cols),
  .cfg_mode (cfg_mode),
  .cfg_dir  (cfg_dir),
  .rd_en    (rd_en),
  .rd_col   (rd_col),
  .rd_data  (rd_data),
  .row_sel  (row_sel),
  .col_sel  (col_sel),
  .perm_in  (col_gated),
  .perm_out (col_perm)
);

// File: tb/rcm_interleaver_tb_top.sv
module rcm_interleaver_tb_top;

  localparam int DIM        = 18;
  localparam int AW         = $clog2(DIM);
  localparam int CW         = $clog2(DIM + 1);
  localparam int CLK_PERIOD = 10;

  logic           clk;
  logic           rst_n;
  logic [CW-1:0]  cfg_rows;
  logic [CW-1:0]  cfg_cols;
  logic [1:0]     cfg_mode;
  logic           cfg_dir;
  logic           wr_en;
  logic [AW-1:0]  wr_row;
  logic [DIM-1:0] wr_data;
  logic           rd_en;
  logic [AW-1:0]  rd_col;
  logic [DIM-1:0] rd_data;

  int n_chk;
  int n_fail;

  logic [DIM-1:0] m_mem [DIM];
  logic [DIM-1:0] m_rd;
  logic [DIM-1:0] last_sample;
  string          pend_tag;

  rcm_interleaver #(.DIM(DIM)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_rows (cfg_rows),
    .cfg_cols (cfg_cols),
    .cfg_mode (cfg_mode),
    .cfg_dir  (cfg_dir),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_col   (rd_col),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DIM-1:0] f_mask(input int n);
    logic [DIM-1:0] m;
    for (int i = 0; i < DIM; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [DIM-1:0] f_perm(input logic [DIM-1:0] w, input int sel);
    logic [DIM-1:0] r;
    for (int i = 0; i < DIM; i++) begin
      int j;
      case (sel)
        1:       j = i ^ 1;
        2:       j = 3 * (i / 3) + ((i % 3) + 1) % 3;
        3:       j = 3 * (i / 3) + ((i % 3) + 2) % 3;
        default: j = i;
      endcase
      if (j >= DIM) j = i;
      r[i] = w[j];
    end
    return r;
  endfunction

  function automatic int f_csel(input int mode, input int a);
    if (mode == 2) return (a % 2 == 1) ? 1 : 0;
    if (mode == 3) return (a % 3 == 0) ? 0 : ((a % 3 == 1) ? 2 : 3);
    return 0;
  endfunction

  function automatic int f_inv(input int s);
    if (s == 2) return 3;
    if (s == 3) return 2;
    return s;
  endfunction

  function automatic string f_tag(input int mode, input logic dir, input logic re, input int ra);
    if (!re || ra >= int'(cfg_cols)) return "R3";
    if (dir) return "R10";
    if (mode == 2) return "R8";
    if (mode == 3) return "R9";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [DIM-1:0] act, input logic [DIM-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample_out();
    last_sample = rd_data;
    chk(pend_tag, rd_data, m_rd);
  endtask

  task automatic tick(input logic we, input int wa, input logic [DIM-1:0] wd,
                      input logic re, input int ra, input string tag);
    int rows;
    int cols;
    int mode;
    logic [DIM-1:0] col;
    @(negedge clk);
    sample_out();
    wr_en   = we;
    wr_row  = AW'(wa);
    wr_data = wd;
    rd_en   = re;
    rd_col  = AW'(ra);
    rows = int'(cfg_rows);
    cols = int'(cfg_cols);
    mode = int'(cfg_mode);
    if (re && ra < cols && ra < DIM) begin
      for (int k = 0; k < DIM; k++) col[k] = m_mem[k][ra];
      col  = col & f_mask(rows);
      m_rd = f_perm(col, cfg_dir ? 0 : f_csel(mode, ra)) & f_mask(rows);
    end
    if (we && wa < rows && wa < DIM) begin
      col = f_perm(wd, cfg_dir ? f_inv(f_csel(mode, wa)) : 0) & f_mask(cols);
      m_mem[wa] = (m_mem[wa] & ~f_mask(cols)) | col;
    end
    pend_tag = tag;
  endtask

  task automatic set_cfg(input int rows, input int cols, input int mode, input logic dir,
                         input string tag);
    @(negedge clk);
    sample_out();
    cfg_rows = CW'(rows);
    cfg_cols = CW'(cols);
    cfg_mode = 2'(mode);
    cfg_dir  = dir;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    pend_tag = tag;
  endtask

  task automatic round_trip(input int mode, input int nrows);
    logic [DIM-1:0] orig [DIM];
    logic [DIM-1:0] cout [DIM];
    set_cfg(nrows, 16, mode, 1'b0, "R10");
    for (int r = 0; r < nrows; r++) begin
      orig[r] = DIM'($urandom) & f_mask(16);
      tick(1'b1, r, orig[r], 1'b0, 0, "R10");
    end
    for (int c = 0; c < 16; c++) begin
      tick(1'b0, 0, '0, 1'b1, c, "R10");
      tick(1'b0, 0, '0, 1'b0, 0, "R10");
      cout[c] = last_sample;
    end
    set_cfg(16, nrows, mode, 1'b1, "R10");
    for (int c = 0; c < 16; c++) tick(1'b1, c, cout[c], 1'b0, 0, "R10");
    for (int k = 0; k < nrows; k++) begin
      tick(1'b0, 0, '0, 1'b1, k, "R10");
      tick(1'b0, 0, '0, 1'b0, 0, "R10");
      chk("R10 round trip", last_sample, orig[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    void'($urandom(32'd4711));
    rst_n    = 1'b0;
    cfg_rows = CW'(18);
    cfg_cols = CW'(18);
    cfg_mode = 2'd0;
    cfg_dir  = 1'b0;
    wr_en    = 1'b0;
    wr_row   = '0;
    wr_data  = '0;
    rd_en    = 1'b0;
    rd_col   = '0;
    m_rd     = '0;
    pend_tag = "R1";
    for (int r = 0; r < DIM; r++) m_mem[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: output and every cell start cleared
    set_cfg(18, 18, 0, 1'b0, "R1");
    for (int c = 0; c < DIM; c++) tick(1'b0, 0, '0, 1'b1, c, "R1");

    // R2, R11: 3x16 block in 19 back-to-back issue cycles
    set_cfg(3, 16, 0, 1'b0, "R2");
    for (int r = 0; r < 3; r++) tick(1'b1, r, DIM'($urandom), 1'b0, 0, "R2 R11");
    for (int c = 0; c < 16; c++) tick(1'b0, 0, '0, 1'b1, c, "R2 R11");
    // R11: same-cycle read sees pre-write contents
    tick(1'b1, 1, '1, 1'b1, 5, "R11");
    tick(1'b0, 0, '0, 1'b1, 5, "R11");

    // R4: out-of-range row writes leave cells alone
    set_cfg(6, 16, 0, 1'b0, "R4");
    tick(1'b1, 7, '1, 1'b0, 0, "R4");
    tick(1'b1, 20, '1, 1'b0, 0, "R4");
    set_cfg(18, 18, 0, 1'b0, "R4");
    for (int c = 0; c < DIM; c++) tick(1'b0, 0, '0, 1'b1, c, "R4");

    // R5: bits past the active column count keep old contents
    tick(1'b1, 0, '1, 1'b0, 0, "R5");
    set_cfg(18, 10, 0, 1'b0, "R5");
    tick(1'b1, 0, '0, 1'b0, 0, "R5");
    set_cfg(18, 18, 0, 1'b0, "R5");
    tick(1'b0, 0, '0, 1'b1, 12, "R5");
    tick(1'b0, 0, '0, 1'b1, 4, "R5");

    // R3: out-of-range reads and idle cycles hold rd_data
    set_cfg(18, 16, 0, 1'b0, "R3");
    tick(1'b0, 0, '0, 1'b1, 12, "R3");
    tick(1'b0, 0, '0, 1'b1, 16, "R3");
    tick(1'b0, 0, '0, 1'b1, 31, "R3");
    tick(1'b0, 0, '0, 1'b0, 2, "R3");

    // R6: high rows masked after the rotation network
    for (int r = 0; r < DIM; r++) tick(1'b1, r, '1, 1'b0, 0, "R6");
    set_cfg(5, 18, 3, 1'b0, "R6");
    for (int c = 0; c < 6; c++) tick(1'b0, 0, '0, 1'b1, c, "R6");

    // R7, R8, R9: each constellation mode with full column sweeps
    set_cfg(6, 16, 1, 1'b0, "R7");
    for (int r = 0; r < 6; r++) tick(1'b1, r, DIM'($urandom), 1'b0, 0, "R7");
    for (int c = 0; c < 16; c++) tick(1'b0, 0, '0, 1'b1, c, "R7");
    set_cfg(12, 16, 2, 1'b0, "R8");
    for (int r = 0; r < 12; r++) tick(1'b1, r, DIM'($urandom), 1'b0, 0, "R8");
    for (int c = 0; c < 16; c++) tick(1'b0, 0, '0, 1'b1, c, "R8");
    set_cfg(18, 16, 3, 1'b0, "R9");
    for (int r = 0; r < 18; r++) tick(1'b1, r, DIM'($urandom), 1'b0, 0, "R9");
    for (int c = 0; c < 16; c++) tick(1'b0, 0, '0, 1'b1, c, "R9");

    // R10: interleave then deinterleave, every mode
    round_trip(0, 3);
    round_trip(1, 6);
    round_trip(2, 12);
    round_trip(3, 18);

    // Random traffic across shapes, modes and directions
    for (int blk = 0; blk < 40; blk++) begin
      int md;
      logic dr;
      md = int'($urandom_range(0, 3));
      dr = 1'($urandom_range(0, 1));
      set_cfg(int'($urandom_range(1, 18)), int'($urandom_range(1, 18)), md, dr, "R2");
      for (int n = 0; n < 60; n++) begin
        logic we;
        logic re;
        int   ra;
        we = ($urandom_range(0, 1) == 1);
        re = ($urandom_range(0, 9) < 6);
        ra = int'($urandom_range(0, 21));
        tick(we, int'($urandom_range(0, 21)), DIM'($urandom), re, ra, f_tag(md, dr, re, ra));
      end
    end

    @(negedge clk);
    sample_out();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule